// File: doc/BRIEF.md
# SMART Subcommand Handler

This block sits behind a storage device's command decoder and services the health-monitoring command (opcode B0h). The Features value selects the subcommand. The block keeps a monitoring-enabled flag, which software can persist, and an attribute-autosave flag. It answers the health-status query by loading the two mid and high address result bytes with a fixed signature pair. It can also stream a 512-byte health data record, whose final byte is a checksum.

Attribute collection and self-test execution are outside the block. The runtime bad-block count is an input, and starting an off-line collection produces a one-cycle strobe. The enable flag is presented on a save port and can be reloaded through a restore port. The surrounding logic uses these ports to carry the flag across a power cycle.

Each accepted command ends with a one-cycle `done` pulse. `aborted` is raised in that same cycle when the command is rejected.

Top module: `smart_cmd_unit`

## Requirements
- R1: A command is accepted only when `cmd_valid` is high, `busy` is low and `cmd_code` equals B0h. Any other opcode produces no `done` and no `aborted`, and leaves every flag and result register unchanged.
- R2: Features codes are D0h (read record), D2h (autosave control), D4h (start off-line collection), D8h (enable), D9h (disable) and DAh (status query). Any other Features value is aborted. An abort raises `done` and `aborted` together in the cycle after acceptance, and both result bytes keep their previous values.
- R3: While monitoring is disabled, every subcommand other than D8h is aborted. It changes no flag and starts no stream.
- R4: The status query loads `lba_mid`/`lba_high` with 4Fh/C2h when `thresh_hit` is low and with F4h/2Ch when it is high. The new values are visible together with `done` in the cycle after acceptance.
- R5: D8h sets the enable flag. Issued while already enabled, it completes without abort and leaves the autosave flag unchanged.
- R6: D9h clears the enable flag. D2h sets the autosave flag when `sect_cnt` is nonzero and clears it when `sect_cnt` is zero. Both flags are 0 after reset.
- R7: D0h emits 512 bytes on consecutive cycles, starting the cycle after acceptance, with `rd_last` marking only the final byte. Byte 0 is the low half of the format revision and byte 1 the high half (default revision 0102h). Bytes 398 and 399 hold `bad_blk_cnt`, most significant byte first, sampled at acceptance. All other bytes except 511 are zero.
- R8: Byte 511 is chosen so that the sum of all 512 bytes is zero modulo 256.
- R9: `done` rises in the cycle after the final byte. `busy` is high during the stream, and commands presented then are ignored.
- R10: `nv_en_out` always shows the enable flag, which reset clears. A `nv_load` pulse copies `nv_en_in` into it, taking priority over a command in the same cycle.
- R11: An accepted D4h raises `offline_go` for one cycle, aligned with its `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_valid | input | 1 | Command presented this cycle |
| cmd_code | input | 8 | Command opcode |
| feature | input | 8 | Subcommand selector |
| sect_cnt | input | 8 | Count field; autosave on when nonzero |
| thresh_hit | input | 1 | Threshold-exceeded condition from attribute logic |
| bad_blk_cnt | input | 16 | Runtime bad-block count from attribute logic |
| nv_load | input | 1 | Restore the persisted enable flag |
| nv_en_in | input | 1 | Persisted enable value to restore |
| nv_en_out | output | 1 | Enable flag to persist |
| autosave_on | output | 1 | Autosave flag |
| busy | output | 1 | Record stream in progress |
| done | output | 1 | Command completed (one cycle) |
| aborted | output | 1 | Completed command was rejected |
| lba_mid | output | 8 | Status signature, mid byte |
| lba_high | output | 8 | Status signature, high byte |
| offline_go | output | 1 | Start strobe for off-line collection |
| rd_valid | output | 1 | Record byte valid |
| rd_data | output | 8 | Record byte |
| rd_last | output | 1 | Final record byte |

## Verification
The bench builds the block with its defaults: a 512-byte record, the bad-block field at byte 398 and revision 0102h. These defaults bring the full-length stream within reach, so the checksum is checked over every byte with two different bad-block counts, including FFFFh, which wraps the running sum. A mid-stream disable command checks that inputs are ignored while busy. A reset followed by a restore through the save port checks that the enable flag survives a power cycle, and the disabled state is exercised both before any enable and after it.

// File: rtl/smart_pkg.sv
package smart_pkg;
  localparam logic [7:0] OPC_SMART = 8'hB0;
  localparam logic [7:0] FT_READ   = 8'hD0;
  localparam logic [7:0] FT_AUTO   = 8'hD2;
  localparam logic [7:0] FT_OFFL   = 8'hD4;
  localparam logic [7:0] FT_ENA    = 8'hD8;
  localparam logic [7:0] FT_DIS    = 8'hD9;
  localparam logic [7:0] FT_STAT   = 8'hDA;

  localparam logic [7:0] SIG_OK_MID   = 8'h4F;
  localparam logic [7:0] SIG_OK_HIGH  = 8'hC2;
  localparam logic [7:0] SIG_BAD_MID  = 8'hF4;
  localparam logic [7:0] SIG_BAD_HIGH = 8'h2C;

  typedef enum logic [2:0] {
    K_NONE, K_ABORT, K_ENA, K_DIS, K_AUTO, K_OFFL, K_STAT, K_READ
  } smart_kind_t;
endpackage

// File: rtl/smart_decode.sv
module smart_decode
  import smart_pkg::*;
(
  input  logic [7:0]  cmd_code,
  input  logic [7:0]  feature,
  input  logic        en,
  output smart_kind_t kind
);
  always_comb begin
    kind = K_NONE;
    if (cmd_code == OPC_SMART) begin
      if (feature == FT_ENA) begin
        kind = K_ENA;
      end else if (!en) begin
        kind = K_ABORT;
      end else begin
        case (feature)
          FT_DIS:  kind = K_DIS;
          FT_AUTO: kind = K_AUTO;
          FT_OFFL: kind = K_OFFL;
          FT_STAT: kind = K_STAT;
          FT_READ: kind = K_READ;
          default: kind = K_ABORT;
        endcase
      end
    end
  end
endmodule

// File: rtl/smart_flags.sv
module smart_flags
  import smart_pkg::*;
#(
  parameter logic EN_RST = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        accept,
  input  smart_kind_t kind,
  input  logic [7:0]  sect_cnt,
  input  logic        nv_load,
  input  logic        nv_val,
  output logic        en,
  output logic        autosave
);
  logic en_q, en_d, as_q, as_d;

  always_comb begin
    en_d = en_q;
    as_d = as_q;
    if (nv_load) begin
      en_d = nv_val;
    end else if (accept) begin
      case (kind)
        K_ENA:   en_d = 1'b1;
        K_DIS:   en_d = 1'b0;
        K_AUTO:  as_d = (sect_cnt != 8'h00);
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= EN_RST;
      as_q <= 1'b0;
    end else begin
      en_q <= en_d;
      as_q <= as_d;
    end
  end

  assign en       = en_q;
  assign autosave = as_q;

  AST_ENA_KEEPS_AUTOSAVE: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && kind == K_ENA && !nv_load) |=> ($stable(autosave) && en)); // R5
  AST_ABORT_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && kind == K_ABORT && !nv_load) |=> ($stable(en) && $stable(autosave))); // R3
endmodule

// File: rtl/smart_stream.sv
module smart_stream #(
  parameter int          REC_BYTES = 512,
  parameter int          BB_POS    = 398,
  parameter logic [15:0] FMT_REV   = 16'h0102
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [15:0] bb_in,
  output logic        valid,
  output logic [7:0]  data,
  output logic        last
);
  localparam int IDX_W = $clog2(REC_BYTES);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(REC_BYTES - 1);
  localparam logic [IDX_W-1:0] BB_HI    = IDX_W'(BB_POS);
  localparam logic [IDX_W-1:0] BB_LO    = IDX_W'(BB_POS + 1);

  logic             act_q, act_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [7:0]       sum_q, sum_d;
  logic [15:0]      bb_q, bb_d;
  logic [7:0]       body;

  always_comb begin
    case (idx_q)
      IDX_W'(0): body = FMT_REV[7:0];
      IDX_W'(1): body = FMT_REV[15:8];
      BB_HI:     body = bb_q[15:8];
      BB_LO:     body = bb_q[7:0];
      default:   body = 8'h00;
    endcase
  end

  assign valid = act_q;
  assign last  = act_q && (idx_q == LAST_IDX);
  assign data  = (idx_q == LAST_IDX) ? (8'h00 - sum_q) : body;

  always_comb begin
    act_d = act_q;
    idx_d = idx_q;
    sum_d = sum_q;
    bb_d  = bb_q;
    if (start) begin
      act_d = 1'b1;
      idx_d = '0;
      sum_d = 8'h00;
      bb_d  = bb_in;
    end else if (act_q) begin
      if (idx_q == LAST_IDX) begin
        act_d = 1'b0;
      end else begin
        idx_d = idx_q + 1'b1;
        sum_d = sum_q + body;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      idx_q <= '0;
      sum_q <= 8'h00;
      bb_q  <= 16'h0000;
    end else begin
      act_q <= act_d;
      idx_q <= idx_d;
      sum_q <= sum_d;
      bb_q  <= bb_d;
    end
  end

  AST_LAST_ENDS_STREAM: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && last && !start) |=> !valid); // R7
  AST_STREAM_NO_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !last) |=> valid); // R7
endmodule

// File: rtl/smart_cmd_unit.sv
module smart_cmd_unit
  import smart_pkg::*;
#(
  parameter int          REC_BYTES = 512,
  parameter int          BB_POS    = 398,
  parameter logic [15:0] FMT_REV   = 16'h0102,
  parameter logic        EN_RST    = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  input  logic [7:0]  cmd_code,
  input  logic [7:0]  feature,
  input  logic [7:0]  sect_cnt,
  input  logic        thresh_hit,
  input  logic [15:0] bad_blk_cnt,
  input  logic        nv_load,
  input  logic        nv_en_in,
  output logic        nv_en_out,
  output logic        autosave_on,
  output logic        busy,
  output logic        done,
  output logic        aborted,
  output logic [7:0]  lba_mid,
  output logic [7:0]  lba_high,
  output logic        offline_go,
  output logic        rd_valid,
  output logic [7:0]  rd_data,
  output logic        rd_last
);
  logic [1:0]  rst_sync;
  logic        rst_s_n;
  logic        en;
  smart_kind_t kind;
  logic        accept, start_rd;
  logic        done_q, done_d, abort_q, abort_d, go_q, go_d;
  logic [7:0]  mid_q, mid_d, high_q, high_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_s_n = rst_sync[1];

  smart_decode u_dec (
    .cmd_code (cmd_code),
    .feature  (feature),
    .en       (en),
    .kind     (kind)
  );

  assign accept   = cmd_valid && !busy && (kind != K_NONE);
  assign start_rd = accept && (kind == K_READ);

  smart_flags #(.EN_RST(EN_RST)) u_flags (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .accept   (accept),
    .kind     (kind),
    .sect_cnt (sect_cnt),
    .nv_load  (nv_load),
    .nv_val   (nv_en_in),
    .en       (en),
    .autosave (autosave_on)
  );

  smart_stream #(
    .REC_BYTES (REC_BYTES),
    .BB_POS    (BB_POS),
    .FMT_REV   (FMT_REV)
  ) u_stream (
    .clk   (clk),
    .rst_n (rst_s_n),
    .start (start_rd),
    .bb_in (bad_blk_cnt),
    .valid (rd_valid),
    .data  (rd_data),
    .last  (rd_last)
  );

  assign busy = rd_valid;

  always_comb begin
    done_d  = (accept && kind != K_READ) || (rd_valid && rd_last);
    abort_d = accept && (kind == K_ABORT);
    go_d    = accept && (kind == K_OFFL);
    mid_d   = mid_q;
    high_d  = high_q;
    if (accept && kind == K_STAT) begin
      mid_d  = thresh_hit ? SIG_BAD_MID  : SIG_OK_MID;
      high_d = thresh_hit ? SIG_BAD_HIGH : SIG_OK_HIGH;
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      done_q  <= 1'b0;
      abort_q <= 1'b0;
      go_q    <= 1'b0;
      mid_q   <= 8'h00;
      high_q  <= 8'h00;
    end else begin
      done_q  <= done_d;
      abort_q <= abort_d;
      go_q    <= go_d;
      mid_q   <= mid_d;
      high_q  <= high_d;
    end
  end

  assign done       = done_q;
  assign aborted    = abort_q;
  assign offline_go = go_q;
  assign lba_mid    = mid_q;
  assign lba_high   = high_q;
  assign nv_en_out  = en;

  AST_FOREIGN_OPCODE_QUIET: assert property (@(posedge clk) disable iff (!rst_s_n)
    (cmd_valid && cmd_code != OPC_SMART && !busy) |=> !done); // R1
  AST_DISABLED_ABORTS: assert property (@(posedge clk) disable iff (!rst_s_n)
    (cmd_valid && !busy && cmd_code == OPC_SMART && !nv_en_out && feature != FT_ENA)
      |=> (done && aborted)); // R3
  AST_STATUS_SIGNATURE: assert property (@(posedge clk) disable iff (!rst_s_n)
    (accept && kind == K_STAT) |=> (done && !aborted &&
      ((lba_mid == SIG_OK_MID && lba_high == SIG_OK_HIGH) ||
       (lba_mid == SIG_BAD_MID && lba_high == SIG_BAD_HIGH)))); // R4
  AST_ABORT_HOLDS_RESULT: assert property (@(posedge clk) disable iff (!rst_s_n)
    (accept && kind == K_ABORT) |=> ($stable(lba_mid) && $stable(lba_high))); // R2
  AST_OFFLINE_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_s_n)
    offline_go |-> (done && !aborted)); // R11
endmodule

// File: tb/tb_smart_cmd_unit.sv
`timescale 1ns/1ps
module tb_smart_cmd_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_valid;
  logic [7:0]  cmd_code, feature, sect_cnt;
  logic        thresh_hit;
  logic [15:0] bad_blk_cnt;
  logic        nv_load, nv_en_in;
  logic        nv_en_out, autosave_on, busy, done, aborted, offline_go;
  logic        rd_valid, rd_last;
  logic [7:0]  lba_mid, lba_high, rd_data;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;
  logic [8:0] exp_q[$];

  always #2.5 clk = ~clk;

  smart_cmd_unit dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .feature(feature), .sect_cnt(sect_cnt), .thresh_hit(thresh_hit),
    .bad_blk_cnt(bad_blk_cnt), .nv_load(nv_load), .nv_en_in(nv_en_in),
    .nv_en_out(nv_en_out), .autosave_on(autosave_on), .busy(busy),
    .done(done), .aborted(aborted), .lba_mid(lba_mid), .lba_high(lba_high),
    .offline_go(offline_go), .rd_valid(rd_valid), .rd_data(rd_data),
    .rd_last(rd_last)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard for every streamed byte
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R7 unexpected byte actual=%0h expected=none", {rd_last, rd_data});
      end else begin
        logic [8:0] e;
        e = exp_q.pop_front();
        if ({rd_last, rd_data} !== e) begin
          fails++;
          $display("FAIL R7/R8 stream byte actual=%0h expected=%0h", {rd_last, rd_data}, e);
        end
      end
    end
  end

  // Driver side of the scoreboard: the expected record
  task automatic push_record(input logic [15:0] bb);
    logic [7:0] sum = 8'h00;
    for (int i = 0; i < 511; i++) begin
      logic [7:0] b;
      b = (i == 0) ? 8'h02 : (i == 1) ? 8'h01 :
          (i == 398) ? bb[15:8] : (i == 399) ? bb[7:0] : 8'h00;
      sum = sum + b;
      exp_q.push_back({1'b0, b});
    end
    exp_q.push_back({1'b1, 8'h00 - sum});
  endtask

  task automatic send(input logic [7:0] code, input logic [7:0] ft, input logic [7:0] cnt);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_code = code; feature = ft; sect_cnt = cnt;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(100000 * 5);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic saved;
    cmd_valid = 0; cmd_code = 0; feature = 0; sect_cnt = 0; thresh_hit = 0;
    bad_blk_cnt = 0; nv_load = 0; nv_en_in = 0;
    do_reset();

    // Reset state
    chk("R10 reset enable", nv_en_out, 0);
    chk("R6 reset autosave", autosave_on, 0);
    chk("R9 reset busy", busy, 0);
    chk("R2 reset done", done, 0);
    chk("R4 reset result", {lba_mid, lba_high}, 16'h0000);

    // Disabled: status query aborts, result held
    send(8'hB0, 8'hDA, 8'h00);
    chk("R3 disabled status done/abort", {done, aborted}, 2'b11);
    chk("R3 disabled status result held", {lba_mid, lba_high}, 16'h0000);
    // Disabled: read aborts, no stream
    send(8'hB0, 8'hD0, 8'h00);
    chk("R3 disabled read aborts", {done, aborted}, 2'b11);
    @(negedge clk);
    chk("R3 disabled read no stream", rd_valid, 0);
    // Disabled: autosave control aborts, flag unchanged
    send(8'hB0, 8'hD2, 8'h01);
    chk("R3 disabled autosave aborts", {done, aborted}, 2'b11);
    chk("R3 disabled autosave unchanged", autosave_on, 0);

    // Foreign opcode ignored
    send(8'hEC, 8'hD8, 8'h00);
    chk("R1 foreign opcode no done", {done, aborted}, 2'b00);
    chk("R1 foreign opcode no enable", nv_en_out, 0);

    // Enable
    send(8'hB0, 8'hD8, 8'h00);
    chk("R5 enable completes", {done, aborted}, 2'b10);
    chk("R5 enable flag", nv_en_out, 1);
    send(8'hB0, 8'hD2, 8'hF1);
    chk("R6 autosave set", autosave_on, 1);
    send(8'hB0, 8'hD8, 8'h00);
    chk("R5 re-enable no abort", {done, aborted}, 2'b10);
    chk("R5 re-enable keeps autosave", autosave_on, 1);
    send(8'hB0, 8'hD2, 8'h00);
    chk("R6 autosave cleared", autosave_on, 0);

    // Status query
    thresh_hit = 0;
    send(8'hB0, 8'hDA, 8'h00);
    chk("R4 healthy signature", {done, aborted, lba_mid, lba_high}, {2'b10, 16'h4FC2});
    thresh_hit = 1;
    send(8'hB0, 8'hDA, 8'h00);
    chk("R4 exceeded signature", {done, aborted, lba_mid, lba_high}, {2'b10, 16'hF42C});

    // Unknown Features value
    send(8'hB0, 8'h55, 8'h00);
    chk("R2 unknown feature aborts", {done, aborted}, 2'b11);
    chk("R2 unknown feature holds result", {lba_mid, lba_high}, 16'hF42C);

    // Off-line collection start
    send(8'hB0, 8'hD4, 8'h00);
    chk("R11 offline strobe", {done, aborted, offline_go}, 3'b101);
    @(negedge clk);
    chk("R11 offline strobe one cycle", offline_go, 0);

    // Record read with bad-block count 1234h; disable attempted mid-stream
    bad_blk_cnt = 16'h1234;
    push_record(16'h1234);
    send(8'hB0, 8'hD0, 8'h00);
    chk("R9 read not done at start", done, 0);
    bad_blk_cnt = 16'h9999;
    repeat (20) @(negedge clk);
    chk("R9 busy during stream", busy, 1);
    send(8'hB0, 8'hD9, 8'h00);
    chk("R9 command during stream ignored", done, 0);
    while (!(rd_valid && rd_last)) @(negedge clk);
    @(negedge clk);
    chk("R9 done after last byte", {done, aborted, rd_valid}, 3'b100);
    chk("R7 record fully consumed", exp_q.size(), 0);
    chk("R9 ignored disable left enable", nv_en_out, 1);

    // Second record, count FFFFh
    bad_blk_cnt = 16'hFFFF;
    push_record(16'hFFFF);
    send(8'hB0, 8'hD0, 8'h00);
    while (!(rd_valid && rd_last)) @(negedge clk);
    @(negedge clk);
    chk("R8 second record done", done, 1);
    chk("R8 second record consumed", exp_q.size(), 0);

    // Power cycle with save/restore
    saved = nv_en_out;
    do_reset();
    chk("R10 enable cleared by reset", nv_en_out, 0);
    @(negedge clk);
    nv_load = 1'b1; nv_en_in = saved;
    @(negedge clk);
    nv_load = 1'b0;
    chk("R10 enable restored", nv_en_out, 1);
    thresh_hit = 0;
    send(8'hB0, 8'hDA, 8'h00);
    chk("R10 restored enable serves status", {done, aborted, lba_mid, lba_high}, {2'b10, 16'h4FC2});

    // Disable, then subcommands abort
    send(8'hB0, 8'hD9, 8'h00);
    chk("R6 disable completes", {done, aborted, nv_en_out}, 3'b100);
    send(8'hB0, 8'hD4, 8'h00);
    chk("R3 disabled offline aborts", {done, aborted, offline_go}, 3'b110);
    send(8'hB0, 8'hD9, 8'h00);
    chk("R3 disabled disable aborts", {done, aborted}, 2'b11);

    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule